// File: doc/BRIEF.md
# ARINC 429 word serializer

This block takes 31-bit words from an external queue and sends each one as a 32-bit ARINC 429 frame in bipolar return-to-zero form. A generated parity bit is appended as the last bit. The line state is carried on a pair of outputs. In the first half of each bit cell, one output is raised to mark a one or a zero. In the second half of the cell, and in the gaps between words, both outputs stay low.

Each clock cycle of `clk_i` is one transmit-clock period. The speed select chooses the half-bit length and the inter-word gap. While transmission is enabled and the queue reports a word, the block pops the head word straight into its shift register. After the last bit of a word it pulses a word-done strobe for the queue's word counter, then waits out the gap.

A self-test select routes the stream to two internal loopback pairs, one true and one complemented, and holds the external line pair idle. Speed and parity are captured with each word. Self-test routing is applied live.

Top module: `a429_tx_serializer`

## Requirements
- R1: When idle with `enable_i` and `word_valid_i` high, `pop_o` is high in that same cycle. The first data half-bit appears on the outputs in the next cycle. `pop_o` is never high unless both inputs are high.
- R2: With `speed_lo_i`=0 captured at pop, each data half and each null half lasts 5 cycles. The gap after bit 32 lasts 40 cycles. Back-to-back words are therefore popped 360 cycles apart.
- R3: With `speed_lo_i`=1 captured at pop, each half lasts 40 cycles and the gap lasts 320 cycles, giving 2880 cycles between back-to-back pops.
- R4: Word bits are sent in order from bit 0 to bit 30, and the parity bit follows as the 32nd bit.
- R5: The 32nd bit makes the count of ones in the frame odd when `parity_even_i`=0 at pop, and even when it is 1.
- R6: In a data half, a one drives `line_hi_o`=1, `line_lo_o`=0, and a zero drives `line_hi_o`=0, `line_lo_o`=1. In null halves, gaps and idle, both are 0. Both are never high at once.
- R7: With `self_test_n_i`=0, both line outputs are 0. `loop1_hi_o`/`loop1_lo_o` carry the levels the line pair would carry, and `loop2_hi_o`/`loop2_lo_o` carry them swapped (the complement). With `self_test_n_i`=1, all four loop outputs are 0.
- R8: `word_done_o` is a one-cycle pulse in the last null cycle of the 32nd bit, and it is followed by the gap.
- R9: If `enable_i` is low during a word's data or null halves, all outputs are 0 from the next cycle on. The word is dropped without `word_done_o`, and a new pop can occur as soon as `enable_i` returns.
- R10: An asynchronous low on `rst_ni` drops all outputs to 0 at once and aborts the word. After release the block is idle until the next pop.
- R11: Changing `speed_lo_i` or `parity_even_i` after a pop has no effect on the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | transmit clock, one period per timing count |
| rst_ni | input | 1 | asynchronous active-low reset |
| enable_i | input | 1 | transmission enable |
| word_valid_i | input | 1 | queue holds at least one word |
| word_i | input | 31 | head word of the queue |
| speed_lo_i | input | 1 | 1 = low-speed timing, 0 = high-speed |
| parity_even_i | input | 1 | 1 = even frame parity, 0 = odd |
| self_test_n_i | input | 1 | 0 = internal loopback, line pair idle |
| pop_o | output | 1 | head word taken this cycle |
| word_done_o | output | 1 | last cycle of the 32nd bit |
| line_hi_o | output | 1 | external high line state |
| line_lo_o | output | 1 | external low line state |
| loop1_hi_o | output | 1 | loopback true stream, high state |
| loop1_lo_o | output | 1 | loopback true stream, low state |
| loop2_hi_o | output | 1 | loopback complement stream, high state |
| loop2_lo_o | output | 1 | loopback complement stream, low state |

## Verification
Faults show up at the outputs quickly:
- A wrong phase counter or a wrongly captured speed moves a data edge within one half-bit, and it moves the `word_done_o` pulse and the next `pop_o` by a whole cell or gap.
- A wrong bit index or shift content shows as a wrong data level in the affected bit's data half.
- A wrong parity shows only in bit 32, about 62 half-bits after the pop.
- A state left active after an abort or reset shows as a nonzero line or loop output in the very next cycle.

The bench compares every output in every cycle of each word, so each of these faults is reported in the cycle where it first appears.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_NULL = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/a429_phase_timer.sv
module a429_phase_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || last_o)  cnt_q <= '0;
    else if (run_i)            cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/a429_word_shifter.sv
module a429_word_shifter #(
  parameter int WORD_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              par_even_i,
  input  logic              shift_i,
  output logic              bit_o
);
  localparam int FRAME_W = WORD_W + 1;

  logic [FRAME_W-1:0] sreg_q;
  logic               par_bit;

  // odd frame parity unless even selected
  assign par_bit = (^word_i) ^ ~par_even_i;
  assign bit_o   = sreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sreg_q <= '0;
    else if (load_i)   sreg_q <= {par_bit, word_i};
    else if (shift_i)  sreg_q <= {1'b0, sreg_q[FRAME_W-1:1]};
  end
endmodule

// File: rtl/a429_line_router.sv
module a429_line_router (
  input  logic drive_i,
  input  logic bit_i,
  input  logic self_test_n_i,
  output logic line_hi_o,
  output logic line_lo_o,
  output logic loop1_hi_o,
  output logic loop1_lo_o,
  output logic loop2_hi_o,
  output logic loop2_lo_o
);
  logic hi, lo;

  assign hi = drive_i & bit_i;
  assign lo = drive_i & ~bit_i;

  always_comb begin
    line_hi_o  = 1'b0;
    line_lo_o  = 1'b0;
    loop1_hi_o = 1'b0;
    loop1_lo_o = 1'b0;
    loop2_hi_o = 1'b0;
    loop2_lo_o = 1'b0;
    if (self_test_n_i) begin
      line_hi_o = hi;
      line_lo_o = lo;
    end else begin
      loop1_hi_o = hi;
      loop1_lo_o = lo;
      loop2_hi_o = lo;
      loop2_lo_o = hi;
    end
  end
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int WORD_W  = 31,
  parameter int HS_HALF = 5,
  parameter int HS_GAP  = 40,
  parameter int LS_HALF = 40,
  parameter int LS_GAP  = 320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              speed_lo_i,
  input  logic              parity_even_i,
  input  logic              self_test_n_i,
  output logic              pop_o,
  output logic              word_done_o,
  output logic              line_hi_o,
  output logic              line_lo_o,
  output logic              loop1_hi_o,
  output logic              loop1_lo_o,
  output logic              loop2_hi_o,
  output logic              loop2_lo_o
);
  localparam int FRAME_W = WORD_W + 1;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int MAX_A   = (HS_HALF > HS_GAP) ? HS_HALF : HS_GAP;
  localparam int MAX_B   = (LS_HALF > LS_GAP) ? LS_HALF : LS_GAP;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             spd_q;
  logic [CNT_W-1:0] half_len, gap_len, len;
  logic             run, last, in_word, abort, pop_slot, last_bit, shift_bit, tx_bit;

  assign half_len  = spd_q ? CNT_W'(LS_HALF) : CNT_W'(HS_HALF);
  assign gap_len   = spd_q ? CNT_W'(LS_GAP)  : CNT_W'(HS_GAP);
  assign len       = (state_q == ST_GAP) ? gap_len : half_len;
  assign run       = (state_q != ST_IDLE);
  assign in_word   = (state_q == ST_DATA) || (state_q == ST_NULL);
  assign abort     = in_word && !enable_i;
  assign pop_slot  = (state_q == ST_IDLE) || ((state_q == ST_GAP) && last);
  assign pop_o     = pop_slot && enable_i && word_valid_i;
  assign last_bit  = (idx_q == IDX_W'(FRAME_W - 1));
  assign shift_bit = (state_q == ST_NULL) && last && !abort;
  assign word_done_o = shift_bit && last_bit;

  a429_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (pop_o || abort),
    .len_i  (len),
    .last_o (last)
  );

  a429_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (pop_o),
    .word_i     (word_i),
    .par_even_i (parity_even_i),
    .shift_i    (shift_bit),
    .bit_o      (tx_bit)
  );

  a429_line_router u_route (
    .drive_i       (state_q == ST_DATA),
    .bit_i         (tx_bit),
    .self_test_n_i (self_test_n_i),
    .line_hi_o     (line_hi_o),
    .line_lo_o     (line_lo_o),
    .loop1_hi_o    (loop1_hi_o),
    .loop1_lo_o    (loop1_lo_o),
    .loop2_hi_o    (loop2_hi_o),
    .loop2_lo_o    (loop2_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      spd_q   <= 1'b0;
    end else if (pop_o) begin
      state_q <= ST_DATA;
      idx_q   <= '0;
      spd_q   <= speed_lo_i;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_DATA: begin
          if (abort)     state_q <= ST_IDLE;
          else if (last) state_q <= ST_NULL;
        end
        ST_NULL: begin
          if (abort) state_q <= ST_IDLE;
          else if (last) begin
            if (last_bit) state_q <= ST_GAP;
            else begin
              state_q <= ST_DATA;
              idx_q   <= idx_q + IDX_W'(1);
            end
          end
        end
        ST_GAP: if (last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic word_valid_i,
  input logic self_test_n_i,
  input logic pop_o,
  input logic word_done_o,
  input logic line_hi_o,
  input logic line_lo_o,
  input logic loop1_hi_o,
  input logic loop1_lo_o,
  input logic loop2_hi_o,
  input logic loop2_lo_o
);
  logic any_out;
  assign any_out = line_hi_o | line_lo_o | loop1_hi_o | loop1_lo_o | loop2_hi_o | loop2_lo_o;

  // R1
  pop_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (enable_i && word_valid_i));

  // R1
  first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> any_out);

  // R6
  line_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_hi_o && line_lo_o) && !(loop1_hi_o && loop1_lo_o));

  // R7
  line_idle_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !self_test_n_i |-> (!line_hi_o && !line_lo_o));

  // R7
  loop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_test_n_i |-> !(loop1_hi_o || loop1_lo_o || loop2_hi_o || loop2_lo_o));

  // R8
  done_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_o |=> (!any_out && !word_done_o));

  // R9
  abort_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !any_out);
endmodule

bind a429_tx_serializer a429_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .word_valid_i  (word_valid_i),
  .self_test_n_i (self_test_n_i),
  .pop_o         (pop_o),
  .word_done_o   (word_done_o),
  .line_hi_o     (line_hi_o),
  .line_lo_o     (line_lo_o),
  .loop1_hi_o    (loop1_hi_o),
  .loop1_lo_o    (loop1_lo_o),
  .loop2_hi_o    (loop2_hi_o),
  .loop2_lo_o    (loop2_lo_o)
);

// File: tb/a429_tx_serializer_test.sv
`timescale 1ns/1ps
module a429_tx_serializer_test;
  localparam int HS_H = 5, HS_G = 40, LS_H = 40, LS_G = 320;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        enable_i = 1'b0, word_valid_i = 1'b0;
  logic [30:0] word_i = '0;
  logic        speed_lo_i = 1'b0, parity_even_i = 1'b0, self_test_n_i = 1'b1;
  logic        pop_o, word_done_o, line_hi_o, line_lo_o;
  logic        loop1_hi_o, loop1_lo_o, loop2_hi_o, loop2_lo_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  a429_tx_serializer uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .word_valid_i(word_valid_i),
    .word_i(word_i), .speed_lo_i(speed_lo_i), .parity_even_i(parity_even_i),
    .self_test_n_i(self_test_n_i), .pop_o(pop_o), .word_done_o(word_done_o),
    .line_hi_o(line_hi_o), .line_lo_o(line_lo_o), .loop1_hi_o(loop1_hi_o),
    .loop1_lo_o(loop1_lo_o), .loop2_hi_o(loop2_hi_o), .loop2_lo_o(loop2_lo_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {line_hi_o, line_lo_o, loop1_hi_o, loop1_lo_o, loop2_hi_o, loop2_lo_o};
  endfunction

  function automatic logic [5:0] exp_outs(bit hi, bit lo, bit stn);
    return stn ? {hi, lo, 4'b0000} : {2'b00, hi, lo, lo, hi};
  endfunction

  function automatic bit exp_parity(logic [30:0] w, bit even);
    return (^w) ^ ~even;
  endfunction

  // send one word from idle, check every cycle until end of gap
  task automatic run_word(logic [30:0] w, bit spd, bit par, bit stn);
    int h, g;
    h = spd ? LS_H : HS_H;
    g = spd ? LS_G : HS_G;
    word_i = w; speed_lo_i = spd; parity_even_i = par; self_test_n_i = stn;
    enable_i = 1'b1; word_valid_i = 1'b1;
    #1 chk("R1 pop", pop_o, 1);
    @(posedge clk); #1;
    word_valid_i = 1'b0;
    speed_lo_i = 1'($urandom);       // R11: ignored for word in flight
    parity_even_i = 1'($urandom);
    for (int n = 1; n <= 64*h + g; n++) begin
      int  idx, ph;
      bit  b, hi, lo;
      string req;
      @(negedge clk);
      idx = (n - 1) / (2*h);
      ph  = (n - 1) % (2*h);
      hi = 0; lo = 0;
      if (idx < 32 && ph < h) begin
        b  = (idx < 31) ? w[idx] : exp_parity(w, par);
        hi = b; lo = !b;
        req = (idx == 31) ? "R5 R11" : "R4 R6";
      end else if (idx < 32) req = "R6 null";
      else req = spd ? "R3 gap" : "R2 gap";
      if (!stn) req = {req, " R7"};
      chk(req, outs(), exp_outs(hi, lo, stn));
      chk("R8 done", word_done_o, (n == 64*h) ? 1 : 0);
      chk("R1 no pop", pop_o, 0);
    end
  endtask

  // pop spacing with the queue never empty
  task automatic b2b(bit spd, string req);
    int k;
    speed_lo_i = spd; self_test_n_i = 1'b1;
    enable_i = 1'b1; word_valid_i = 1'b1; word_i = 31'($urandom);
    #1 chk({req, " first pop"}, pop_o, 1);
    k = 0;
    do begin
      @(negedge clk); k++;
      if (pop_o) word_i = 31'($urandom);
    end while (!pop_o && k < 5000);
    chk({req, " pop spacing"}, k, spd ? 64*LS_H + LS_G : 64*HS_H + HS_G);
    word_valid_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_999_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd429));
    #1;
    chk("R10 reset outputs", outs(), 0);
    chk("R10 reset pop", pop_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 idle", outs(), 0);
    chk("R1 no valid no pop", pop_o, 0);

    // directed corners
    run_word(31'h0, 1'b0, 1'b0, 1'b1);            // R5 odd, zero word
    run_word(31'h0, 1'b0, 1'b1, 1'b1);            // R5 even, zero word
    run_word(31'h7fff_ffff, 1'b0, 1'b0, 1'b0);    // R7 loopback
    run_word(31'h1234_5678 >> 1, 1'b1, 1'b1, 1'b1);  // R3 low speed
    // random words
    for (int i = 0; i < 24; i++)
      run_word(31'($urandom), 1'b0, 1'($urandom), 1'($urandom));
    run_word(31'($urandom), 1'b1, 1'($urandom), 1'b0);

    b2b(1'b0, "R2");
    b2b(1'b1, "R3");
    repeat (400) @(negedge clk);

    // R9: enable dropped mid-word
    enable_i = 1'b1; word_valid_i = 1'b1; word_i = 31'h555;
    #1 chk("R9 pop", pop_o, 1);
    @(posedge clk); #1 word_valid_i = 1'b0;
    repeat (17) @(negedge clk);
    enable_i = 1'b0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      chk("R9 null after abort", outs(), 0);
      chk("R9 no done", word_done_o, 0);
    end
    enable_i = 1'b1; word_valid_i = 1'b1; word_i = 31'h2aa;
    #1 chk("R9 repop", pop_o, 1);
    @(posedge clk); #1 word_valid_i = 1'b0;
    repeat (12) @(negedge clk);

    // R10: asynchronous reset mid-word
    rst_ni = 1'b0;
    #1 chk("R10 async null", outs(), 0);
    chk("R10 no done", word_done_o, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      chk("R10 idle after reset", outs(), 0);
    end
    word_valid_i = 1'b1;
    #1 chk("R10 pop after reset", pop_o, 1);
    @(posedge clk); #1 word_valid_i = 1'b0;
    @(negedge clk);
    chk("R1 first bit next cycle", outs(), exp_outs(1'b0, 1'b1, self_test_n_i));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule